// File: doc/BRIEF.md
# Flash Page Write Buffer Loader

This block sits between the bus write path and a flash array programmer. It keeps a page of 128 sixteen-bit words plus one valid flag per word. Software fills the page in one of two ways. The first is a streaming load: one command opens the page, and 128 data writes follow with column addresses rising strictly from 0 to 127. The second is a set of random single-word loads. Once the page is filled, the block asks the external programmer to write it to the array. When the programmer reports completion, the page empties itself.

Bus writes arrive on a valid/ready port. A write is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops for the whole time a commit is outstanding, so the bus is held back rather than dropped. While held back, the bus must keep `wr_addr` and `wr_data` stable and keep `wr_valid` high. The commit side uses a plain request/done handshake. It offers the page base address, a per-word valid mask and a combinational read port into the page. Sequence violations produce a one-cycle error pulse.

Top module: `pgbuf_loader`

## Requirements
- R1: After reset the page is empty (`commit_mask` all zero), `commit_req` and `err` are low, `wr_ready` is high, and `rd_data` reads 16'hFFFF for every column.
- R2: A command write with 8'h41 in `wr_data[7:0]` discards the page and starts a stream. The stream may target any address. The next 128 writes load `wr_data` at column `wr_addr[6:0]`, and the columns must be 0,1,...,127 in order. The page base `wr_addr[19:7]` is latched on the first data write. One cycle after the 128th write is accepted, `commit_req` rises with an all-ones mask and that base.
- R3: During a stream, a data write whose column is not the next expected one ends the stream. It empties the page, raises `err` for one cycle and issues no commit.
- R4: During a stream, a data write whose `wr_addr[19:7]` differs from the latched base is treated the same way as R3.
- R5: Command 8'h74 followed by one write loads `wr_data` at column `wr_addr[6:0]` and sets that column's mask bit. This works only when `wr_addr` is below 131072 (bank I). Loading an already-loaded column overwrites it.
- R6: A single-word load is rejected with a one-cycle `err`, and the page is left unchanged, in two cases: the address is outside bank I, or the page already holds words and `wr_addr[19:7]` differs from the held base.
- R7: Command 8'h0E followed by a write with 8'hD0 in `wr_data[7:0]` at a bank I address raises `commit_req` one cycle later. The request carries the mask of the loaded words and their base. Three cases instead give `err` with no commit and an unchanged page: a second byte other than 8'hD0, an empty page, or an address outside bank I.
- R8: Command 8'h55 followed by 8'hD0 empties the page. A second byte other than 8'hD0 gives `err` and leaves the page unchanged.
- R9: `commit_req`, `commit_base` and `commit_mask` hold steady, and `wr_ready` stays low, until `commit_done` is seen high. On the edge that samples `commit_done`, the page empties and `wr_ready` returns.
- R10: A column that was never loaded shows a zero mask bit and reads 16'hFFFF, so the array leaves it unprogrammed.
- R11: When no sequence is open, a command byte other than 8'h41, 8'h74, 8'h0E or 8'h55 is ignored. It raises no `err` and leaves the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Bus write can be taken this cycle |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Write data; command byte in bits 7:0 |
| commit_req | output | 1 | Page programming requested |
| commit_base | output | 13 | Page base (address bits 19:7) |
| commit_mask | output | 128 | One bit per loaded column |
| commit_done | input | 1 | Programmer finished the page |
| rd_col | input | 7 | Column read by the programmer |
| rd_data | output | 16 | Word at `rd_col`, 16'hFFFF if not loaded |
| err | output | 1 | One-cycle pulse on a sequence error |

## Verification
The bench targets the exact last column of a stream. A design that miscounts would commit after 127 or 129 writes, or would never commit. It also tries an out-of-order column and a changed page base partway through a stream. A design that is too lenient here would commit a corrupt page, and one that forgets to discard would leave stale words readable. Further cases are a wrong confirm byte, a commit of an empty page, and single loads that cross banks or pages. Each of these must raise the error without touching the page, so a design that loads first and checks afterwards would show changed words. Every commit is compared, word by word, against a model page, and the page is then checked to be empty after the done handshake.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  localparam logic [7:0] OP_STREAM  = 8'h41;
  localparam logic [7:0] OP_SINGLE  = 8'h74;
  localparam logic [7:0] OP_COMMIT  = 8'h0E;
  localparam logic [7:0] OP_DISCARD = 8'h55;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    PB_IDLE,
    PB_STREAM,
    PB_SGL_DATA,
    PB_CMT_CONF,
    PB_CLR_CONF,
    PB_BUSY
  } pb_state_e;

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int WORDS = 128,
  parameter int DW    = 16,
  localparam int CW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CW-1:0]    wcol,
  input  logic [DW-1:0]    wdata,
  input  logic             clr,
  output logic [WORDS-1:0] valid,
  input  logic [CW-1:0]    rcol,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [WORDS];

  // one register per column; valid flags carry the real state
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && wcol == CW'(i)) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   valid <= '0;
    else if (clr) valid <= '0;
    else if (we)  valid[wcol] <= 1'b1;
  end

  // unloaded columns look erased to the programmer
  assign rdata = valid[rcol] ? mem[rcol] : {DW{1'b1}};

endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DW          = 16,
  parameter int WORDS       = 128,
  parameter int BANK1_WORDS = 131072,
  localparam int CW         = $clog2(WORDS),
  localparam int PW         = ADDR_W - CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [WORDS-1:0] mask,
  output logic             buf_we,
  output logic [CW-1:0]    buf_col,
  output logic [DW-1:0]    buf_wdata,
  output logic             buf_clr,
  output logic             commit_req,
  output logic [PW-1:0]    commit_base,
  input  logic             commit_done,
  output logic             err
);

  pb_state_e      st, st_n;
  logic [CW-1:0]  exp_col, exp_col_n;
  logic [PW-1:0]  base_q, base_n;
  logic           err_n;

  logic           acc;
  logic [CW-1:0]  col;
  logic [PW-1:0]  page;
  logic [7:0]     op;
  logic           in_bank1;
  logic           held;

  assign wr_ready  = (st != PB_BUSY);
  assign acc       = wr_valid && wr_ready;
  assign col       = wr_addr[CW-1:0];
  assign page      = wr_addr[ADDR_W-1:CW];
  assign op        = wr_data[7:0];
  assign in_bank1  = (wr_addr < ADDR_W'(BANK1_WORDS));
  assign held      = |mask;
  assign buf_col   = col;
  assign buf_wdata = wr_data;

  always_comb begin
    st_n      = st;
    exp_col_n = exp_col;
    base_n    = base_q;
    buf_we    = 1'b0;
    buf_clr   = 1'b0;
    err_n     = 1'b0;
    if (st == PB_BUSY) begin
      if (commit_done) begin
        buf_clr = 1'b1;
        st_n    = PB_IDLE;
      end
    end else if (acc) begin
      case (st)
        PB_IDLE: begin
          case (op)
            OP_STREAM: begin
              buf_clr   = 1'b1;
              exp_col_n = '0;
              st_n      = PB_STREAM;
            end
            OP_SINGLE:  st_n = PB_SGL_DATA;
            OP_COMMIT:  st_n = PB_CMT_CONF;
            OP_DISCARD: st_n = PB_CLR_CONF;
            default:    st_n = PB_IDLE;
          endcase
        end
        PB_STREAM: begin
          if (col == exp_col && (exp_col == '0 || page == base_q)) begin
            buf_we    = 1'b1;
            exp_col_n = exp_col + 1'b1;
            if (exp_col == '0) base_n = page;
            if (exp_col == CW'(WORDS - 1)) st_n = PB_BUSY;
          end else begin
            buf_clr = 1'b1;
            err_n   = 1'b1;
            st_n    = PB_IDLE;
          end
        end
        PB_SGL_DATA: begin
          if (in_bank1 && (!held || page == base_q)) begin
            buf_we = 1'b1;
            base_n = page;
          end else begin
            err_n = 1'b1;
          end
          st_n = PB_IDLE;
        end
        PB_CMT_CONF: begin
          if (op == OP_CONFIRM && in_bank1 && held) st_n = PB_BUSY;
          else begin
            err_n = 1'b1;
            st_n  = PB_IDLE;
          end
        end
        PB_CLR_CONF: begin
          if (op == OP_CONFIRM) buf_clr = 1'b1;
          else                  err_n   = 1'b1;
          st_n = PB_IDLE;
        end
        default: st_n = PB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PB_IDLE;
      exp_col <= '0;
      base_q  <= '0;
      err     <= 1'b0;
    end else begin
      st      <= st_n;
      exp_col <= exp_col_n;
      base_q  <= base_n;
      err     <= err_n;
    end
  end

  assign commit_req  = (st == PB_BUSY);
  assign commit_base = base_q;

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req && !commit_done |=> commit_req && $stable(commit_base));

  assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req && !commit_done |=> $stable(mask));

  assert_autoclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req && commit_done |=> (mask == '0) && wr_ready);

  assert_full_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_req) && $past(st == PB_STREAM) |-> (&mask));

  assert_nonempty_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_req) |-> (mask != '0));

  assert_err_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !commit_req);

endmodule

// File: rtl/pgbuf_loader.sv
module pgbuf_loader #(
  parameter int ADDR_W      = 20,
  parameter int DW          = 16,
  parameter int WORDS       = 128,
  parameter int BANK1_WORDS = 131072,
  localparam int CW         = $clog2(WORDS),
  localparam int PW         = ADDR_W - CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              commit_req,
  output logic [PW-1:0]     commit_base,
  output logic [WORDS-1:0]  commit_mask,
  input  logic              commit_done,
  input  logic [CW-1:0]     rd_col,
  output logic [DW-1:0]     rd_data,
  output logic              err
);

  logic          buf_we;
  logic          buf_clr;
  logic [CW-1:0] buf_col;
  logic [DW-1:0] buf_wdata;

  pgbuf_ctrl #(
    .ADDR_W(ADDR_W), .DW(DW), .WORDS(WORDS), .BANK1_WORDS(BANK1_WORDS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .mask(commit_mask),
    .buf_we(buf_we), .buf_col(buf_col), .buf_wdata(buf_wdata), .buf_clr(buf_clr),
    .commit_req(commit_req), .commit_base(commit_base),
    .commit_done(commit_done), .err(err)
  );

  pgbuf_store #(.WORDS(WORDS), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .wcol(buf_col), .wdata(buf_wdata), .clr(buf_clr),
    .valid(commit_mask), .rcol(rd_col), .rdata(rd_data)
  );

endmodule

// File: tb/pgbuf_loader_tb_top.sv
module pgbuf_loader_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [19:0]  wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         commit_req;
  logic [12:0]  commit_base;
  logic [127:0] commit_mask;
  logic         commit_done = 1'b0;
  logic [6:0]   rd_col;
  logic [6:0]   main_col = '0;
  logic [6:0]   mon_col = '0;
  logic         mon_busy = 1'b0;
  logic [15:0]  rd_data;
  logic         err;

  int n_chk = 0;
  int n_fail = 0;

  assign rd_col = mon_busy ? mon_col : main_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgbuf_loader dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .commit_base(commit_base),
    .commit_mask(commit_mask), .commit_done(commit_done),
    .rd_col(rd_col), .rd_data(rd_data), .err(err)
  );

  typedef struct packed {
    logic [12:0]   base;
    logic [127:0]  mask;
    logic [2047:0] words;
  } exp_t;

  exp_t          exp_q[$];
  logic [15:0]   m_data [128];
  logic [127:0]  m_mask = '0;
  logic [12:0]   m_base = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic push_commit();
    exp_t e;
    e.base = m_base;
    e.mask = m_mask;
    for (int c = 0; c < 128; c++)
      e.words[c*16 +: 16] = m_mask[c] ? m_data[c] : 16'hFFFF;
    exp_q.push_back(e);
    m_mask = '0;
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    while (!wr_ready) @(negedge clk);
    wr_addr  = a;
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (commit_req || mon_busy) @(negedge clk);
  endtask

  task automatic chk_err(input bit exp, input string tag);
    chk(err == exp, tag, "err pulse", 128'(err), 128'(exp));
  endtask

  task automatic chk_word(input logic [6:0] c, input string tag);
    logic [15:0] ev;
    main_col = c;
    #1;
    ev = m_mask[c] ? m_data[c] : 16'hFFFF;
    chk(rd_data == ev && commit_mask[c] == m_mask[c], tag, "page word",
        {commit_mask[c], rd_data}, {m_mask[c], ev});
  endtask

  // scoreboard monitor: compares each commit against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (commit_req) begin
        exp_t e;
        int bad;
        logic [15:0] first_act, first_exp;
        mon_busy = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R7", "unexpected commit", 128'(commit_base), 128'(0));
          e = '0;
        end else begin
          e = exp_q.pop_front();
        end
        chk(commit_base == e.base, "R2/R7", "commit base", 128'(commit_base), 128'(e.base));
        chk(commit_mask == e.mask, "R2/R7", "commit mask", commit_mask, e.mask);
        chk(!wr_ready, "R9", "ready while busy", 128'(wr_ready), 128'(0));
        bad = 0;
        first_act = '0;
        first_exp = '0;
        for (int c = 0; c < 128; c++) begin
          mon_col = 7'(c);
          #1;
          if (rd_data !== e.words[c*16 +: 16]) begin
            if (bad == 0) begin
              first_act = rd_data;
              first_exp = e.words[c*16 +: 16];
            end
            bad++;
          end
        end
        chk(bad == 0, "R10", "page words", 128'(first_act), 128'(first_exp));
        @(negedge clk);
        chk(commit_req && commit_mask == e.mask, "R9", "request held", commit_mask, e.mask);
        commit_done = 1'b1;
        @(negedge clk);
        commit_done = 1'b0;
        chk(!commit_req && commit_mask == '0 && wr_ready, "R9", "cleared after done",
            commit_mask, 128'(0));
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 128'(0), 128'(1));
    finish_test();
  end

  localparam logic [12:0] PG_B1  = 13'h0012;
  localparam logic [12:0] PG_B1B = 13'h0033;
  localparam logic [12:0] PG_B2  = 13'h1400;

  initial begin
    for (int c = 0; c < 128; c++) m_data[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    main_col = 7'd0;
    #1;
    chk(wr_ready && !commit_req && !err && commit_mask == '0 && rd_data == 16'hFFFF,
        "R1", "reset state", {commit_req, err, rd_data}, 128'hFFFF);

    // R11 foreign command ignored
    wr(20'h0, 16'h0070);
    chk_err(1'b0, "R11");
    chk(commit_mask == '0, "R11", "page untouched", commit_mask, 128'(0));

    // R2 full stream in bank II
    wr({PG_B2, 7'h00}, 16'h0041);
    m_base = PG_B2;
    for (int c = 0; c < 128; c++) begin
      m_data[c] = 16'hA000 ^ 16'(c * 37);
      m_mask[c] = 1'b1;
    end
    push_commit();
    for (int c = 0; c < 128; c++) begin
      wr({PG_B2, 7'(c)}, 16'hA000 ^ 16'(c * 37));
      if (c == 126) chk(!commit_req, "R2", "no early commit", 128'(commit_req), 128'(0));
    end
    chk(commit_req, "R2", "commit after 128th word", 128'(commit_req), 128'(1));
    wait_idle();

    // R3 out-of-order column aborts
    wr({PG_B1, 7'h00}, 16'h0041);
    for (int c = 0; c < 5; c++) wr({PG_B1, 7'(c)}, 16'h1111);
    wr({PG_B1, 7'h06}, 16'h2222);
    chk_err(1'b1, "R3");
    chk(commit_mask == '0 && !commit_req, "R3", "stream discarded", commit_mask, 128'(0));
    wr({PG_B1, 7'h05}, 16'h0070);
    chk_err(1'b0, "R3");

    // R4 base change aborts
    wr({PG_B1, 7'h00}, 16'h0041);
    for (int c = 0; c < 10; c++) wr({PG_B1, 7'(c)}, 16'h3333);
    wr({PG_B1B, 7'd10}, 16'h4444);
    chk_err(1'b1, "R4");
    chk(commit_mask == '0 && !commit_req, "R4", "stream discarded", commit_mask, 128'(0));

    // R5 single loads in bank I
    m_base = PG_B1;
    wr(20'h0, 16'h0074); wr({PG_B1, 7'd3}, 16'h1234);
    m_data[3] = 16'h1234; m_mask[3] = 1'b1;
    chk_err(1'b0, "R5");
    wr(20'h0, 16'h0074); wr({PG_B1, 7'd100}, 16'h5A5A);
    m_data[100] = 16'h5A5A; m_mask[100] = 1'b1;
    wr(20'h0, 16'h0074); wr({PG_B1, 7'd127}, 16'hBEEF);
    m_data[127] = 16'hBEEF; m_mask[127] = 1'b1;
    wr(20'h0, 16'h0074); wr({PG_B1, 7'd3}, 16'h4321);
    m_data[3] = 16'h4321;
    chk_word(7'd3, "R5");
    chk_word(7'd4, "R10");

    // R6 rejected single loads
    wr(20'h0, 16'h0074); wr({PG_B2, 7'd3}, 16'hDEAD);
    chk_err(1'b1, "R6");
    chk_word(7'd3, "R6");
    wr(20'h0, 16'h0074); wr({PG_B1B, 7'd5}, 16'hDEAD);
    chk_err(1'b1, "R6");
    chk_word(7'd5, "R6");

    // R7 bad confirm, then good commit
    wr(20'h0, 16'h000E); wr({PG_B1, 7'd0}, 16'h0000);
    chk_err(1'b1, "R7");
    chk_word(7'd100, "R7");
    wr(20'h0, 16'h000E); wr({PG_B2, 7'd0}, 16'h00D0);
    chk_err(1'b1, "R7");
    chk(!commit_req, "R7", "no commit outside bank", 128'(commit_req), 128'(0));
    push_commit();
    wr(20'h0, 16'h000E); wr({PG_B1, 7'd0}, 16'h00D0);
    chk(commit_req, "R7", "commit requested", 128'(commit_req), 128'(1));
    wait_idle();
    wr(20'h0, 16'h000E); wr({PG_B1, 7'd0}, 16'h00D0);
    chk_err(1'b1, "R7");
    chk(!commit_req, "R7", "empty page not committed", 128'(commit_req), 128'(0));

    // R8 discard sequence
    wr(20'h0, 16'h0074); wr({PG_B1, 7'd9}, 16'h0909);
    m_data[9] = 16'h0909; m_mask[9] = 1'b1;
    wr(20'h0, 16'h0055); wr(20'h0, 16'h00AA);
    chk_err(1'b1, "R8");
    chk_word(7'd9, "R8");
    wr(20'h0, 16'h0055); wr(20'h0, 16'h00D0);
    m_mask = '0;
    chk_err(1'b0, "R8");
    chk_word(7'd9, "R8");
    chk(commit_mask == '0, "R8", "page emptied", commit_mask, 128'(0));

    // R11 foreign command after activity
    wr(20'h0, 16'h00FF);
    chk_err(1'b0, "R11");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R7", "commits outstanding", 128'(exp_q.size()), 128'(0));
    finish_test();
  end

endmodule